// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Resolver

This block answers the processor's interrupt acknowledge for a pair of eight-line interrupt controllers. The second controller feeds line 2 of the first. The request-capture stage and the in-service bookkeeping live outside the block. Each cycle the block sees, for each controller:

- the pending, mask, in-service and trigger-mode vectors,
- a five-bit vector base,
- a priority rotation base,
- an auto end-of-interrupt flag.

Both controllers are arbitrated continuously. The first controller sees its line 2 request as the OR of its own captured bit 2 and "the second controller has a winner". From this the block drives a registered interrupt request line.

When the acknowledge strobe arrives, the cascade is resolved in that same cycle. On the next clock the block presents four things:

- the eight-bit vector number, with a one-cycle valid,
- the request number (0 to 15),
- one-hot strobes that tell the surrounding logic which in-service bits to set,
- one-hot strobes that tell it which pending bits to clear.

The block also watches command writes. An initialization write restarts the addressed controller through a one-cycle strobe. It also drops the interrupt line and latches whether a fourth initialization word is expected.

Top module: `cascade_ack_resolver`

## Requirements
- R1: In each controller, line number `rot` has the highest priority, then `rot+1`, and so on modulo 8. The pending, unmasked line met first in that order wins.
- R2: A pending line cannot win if its own in-service bit is set, or if any line of higher priority is in service. With no winner, the controller counts as having nothing pending.
- R3: A line whose mask bit is 1 is never selected.
- R4: If the first controller's winner is a line L other than 2, the vector is `{p_base, L}`, with the base in bits 7:3 and the line in bits 2:0. The request number is L. Only the first controller's strobes may be nonzero.
- R5: If the first controller's winner is line 2 and the second controller has winner S, the vector is `{s_base, S}` and the request number is S+8. Strobes are raised for line 2 of the first controller and for line S of the second.
- R6: If the first controller's winner is line 2 and the second controller has no winner, the vector is `{s_base, 7}` and the request number is 15. Line 2 of the first controller is still strobed. The second controller gets no strobe.
- R7: If the first controller has no winner at acknowledge time, the vector is `{p_base, 7}`, the request number is 7, and every strobe is zero.
- R8: An acknowledged line raises its in-service-set strobe only when that controller's auto end-of-interrupt flag is 0.
- R9: An acknowledged line raises its pending-clear strobe only when its trigger-mode bit is 0 (edge). A level-mode line (bit = 1) keeps its pending bit.
- R10: `vec_vld_o` is high for exactly the one clock that follows each cycle in which `ack_i` is high, and is low otherwise.
- R11: `int_o` is a registered copy of "the first controller has a winner". It is forced low on the two clocks after an acknowledge, then tracks the updated inputs again.
- R12: A command write with data bit 4 set raises the addressed controller's `init_o` bit for one clock. It latches data bit 0 into that controller's `init4_o` bit and forces `int_o` low for two clocks. A write with bit 4 clear changes neither output.
- R13: While `rst` is high, every output is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ack_i | input | 1 | interrupt acknowledge strobe |
| p_pend_i | input | 8 | first controller pending vector |
| p_mask_i | input | 8 | first controller mask vector |
| p_isr_i | input | 8 | first controller in-service vector |
| p_lvl_i | input | 8 | first controller trigger mode, 1 = level |
| p_base_i | input | 5 | first controller vector base (bits 7:3) |
| p_rot_i | input | 3 | first controller highest-priority line |
| p_aeoi_i | input | 1 | first controller auto end-of-interrupt |
| s_pend_i | input | 8 | second controller pending vector |
| s_mask_i | input | 8 | second controller mask vector |
| s_isr_i | input | 8 | second controller in-service vector |
| s_lvl_i | input | 8 | second controller trigger mode, 1 = level |
| s_base_i | input | 5 | second controller vector base |
| s_rot_i | input | 3 | second controller highest-priority line |
| s_aeoi_i | input | 1 | second controller auto end-of-interrupt |
| cmd_wr_i | input | 1 | command write strobe |
| cmd_dst_i | input | 1 | command target, 0 = first, 1 = second |
| cmd_data_i | input | 8 | command write data |
| vec_o | output | 8 | acknowledged vector number |
| vec_vld_o | output | 1 | vector valid, one clock |
| req_num_o | output | 4 | acknowledged request number 0..15 |
| p_isr_set_o | output | 8 | first controller in-service set strobes |
| p_pend_clr_o | output | 8 | first controller pending clear strobes |
| s_isr_set_o | output | 8 | second controller in-service set strobes |
| s_pend_clr_o | output | 8 | second controller pending clear strobes |
| int_o | output | 1 | interrupt request to processor |
| init_o | output | 2 | per-controller initialization strobe |
| init4_o | output | 2 | per-controller fourth-word-expected flag |

## Verification
Most internal faults surface on the clock after the acknowledge strobe. A wrong arbitration or rotation offset shows up as a wrong low vector field and a wrong one-hot strobe position. A broken cascade decision shows up as the wrong base in bits 7:3, or as a request number missing its bit 3. Faults in the interrupt line appear later: a broken suppression window or a stale re-evaluation is visible on `int_o` during the second and third clocks after the acknowledge. The tests therefore sample `int_o` on each of those clocks, not only once it has settled.

// File: rtl/cascade_ack_pkg.sv
package cascade_ack_pkg;
  // command data bit that starts initialization
  localparam int INIT_BIT = 4;
  // command data bit that announces a fourth init word
  localparam int IC4_BIT  = 0;

  typedef enum logic [1:0] {
    ACK_PRI      = 2'd0,  // ordinary line on the first controller
    ACK_SEC      = 2'd1,  // cascaded line on the second controller
    ACK_SPUR_SEC = 2'd2,  // cascade chosen, second controller empty
    ACK_SPUR_PRI = 2'd3   // first controller empty
  } ack_kind_e;
endpackage

// File: rtl/cascade_line_arbiter.sv
module cascade_line_arbiter #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] msk_i,
  input  logic [LINES-1:0] isr_i,
  input  logic [LW-1:0]    rot_i,
  output logic             hit_o,
  output logic [LW-1:0]    line_o
);
  logic [LW-1:0] idx;
  logic          done;

  // walk lines from highest priority down; an in-service line stops the walk
  always_comb begin
    hit_o  = 1'b0;
    line_o = '0;
    done   = 1'b0;
    idx    = '0;
    for (int k = 0; k < LINES; k++) begin
      idx = LW'((int'(rot_i) + k) % LINES);
      if (!done) begin
        if (isr_i[idx]) begin
          done = 1'b1;
        end else if (req_i[idx] && !msk_i[idx]) begin
          hit_o  = 1'b1;
          line_o = idx;
          done   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cascade_ack_decode.sv
module cascade_ack_decode
  import cascade_ack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VW        = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(LINES),
  localparam int BW = VW - LW
) (
  input  logic             p_hit_i,
  input  logic [LW-1:0]    p_line_i,
  input  logic             s_hit_i,
  input  logic [LW-1:0]    s_line_i,
  input  logic [BW-1:0]    p_base_i,
  input  logic [BW-1:0]    s_base_i,
  input  logic             p_aeoi_i,
  input  logic             s_aeoi_i,
  input  logic [LINES-1:0] p_lvl_i,
  input  logic [LINES-1:0] s_lvl_i,
  output ack_kind_e        kind_o,
  output logic [VW-1:0]    vec_o,
  output logic [LW:0]      num_o,
  output logic [LINES-1:0] p_isr_set_o,
  output logic [LINES-1:0] p_pend_clr_o,
  output logic [LINES-1:0] s_isr_set_o,
  output logic [LINES-1:0] s_pend_clr_o
);
  localparam logic [LW-1:0] SPUR = LW'(LINES - 1);
  localparam logic [LW-1:0] CASC = LW'(CASC_LINE);

  logic [LINES-1:0] p_one, s_one;

  always_comb begin
    if (!p_hit_i)              kind_o = ACK_SPUR_PRI;
    else if (p_line_i != CASC) kind_o = ACK_PRI;
    else if (s_hit_i)          kind_o = ACK_SEC;
    else                       kind_o = ACK_SPUR_SEC;
  end

  always_comb begin
    p_one = '0;
    s_one = '0;
    unique case (kind_o)
      ACK_PRI: begin
        vec_o = {p_base_i, p_line_i};
        num_o = {1'b0, p_line_i};
        p_one[p_line_i] = 1'b1;
      end
      ACK_SEC: begin
        vec_o = {s_base_i, s_line_i};
        num_o = {1'b1, s_line_i};
        p_one[p_line_i] = 1'b1;
        s_one[s_line_i] = 1'b1;
      end
      ACK_SPUR_SEC: begin
        vec_o = {s_base_i, SPUR};
        num_o = {1'b1, SPUR};
        p_one[p_line_i] = 1'b1;
      end
      default: begin
        vec_o = {p_base_i, SPUR};
        num_o = {1'b0, SPUR};
      end
    endcase
  end

  assign p_isr_set_o  = p_aeoi_i ? '0 : p_one;
  assign s_isr_set_o  = s_aeoi_i ? '0 : s_one;
  assign p_pend_clr_o = p_one & ~p_lvl_i;
  assign s_pend_clr_o = s_one & ~s_lvl_i;
endmodule

// File: rtl/cascade_init_track.sv
module cascade_init_track
  import cascade_ack_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          start_o,
  output logic          init_o,
  output logic          init4_o
);
  assign start_o = wr_i && data_i[INIT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      init_o  <= 1'b0;
      init4_o <= 1'b0;
    end else begin
      init_o <= start_o;
      if (start_o) init4_o <= data_i[IC4_BIT];
    end
  end
endmodule

// File: rtl/cascade_ack_resolver.sv
module cascade_ack_resolver
  import cascade_ack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VW        = 8,
  parameter int DW        = 8,
  parameter int CASC_LINE = 2,
  parameter int NCTL      = 2,
  localparam int LW = $clog2(LINES),
  localparam int BW = VW - LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_i,
  input  logic [LINES-1:0] p_pend_i,
  input  logic [LINES-1:0] p_mask_i,
  input  logic [LINES-1:0] p_isr_i,
  input  logic [LINES-1:0] p_lvl_i,
  input  logic [BW-1:0]    p_base_i,
  input  logic [LW-1:0]    p_rot_i,
  input  logic             p_aeoi_i,
  input  logic [LINES-1:0] s_pend_i,
  input  logic [LINES-1:0] s_mask_i,
  input  logic [LINES-1:0] s_isr_i,
  input  logic [LINES-1:0] s_lvl_i,
  input  logic [BW-1:0]    s_base_i,
  input  logic [LW-1:0]    s_rot_i,
  input  logic             s_aeoi_i,
  input  logic             cmd_wr_i,
  input  logic             cmd_dst_i,
  input  logic [DW-1:0]    cmd_data_i,
  output logic [VW-1:0]    vec_o,
  output logic             vec_vld_o,
  output logic [LW:0]      req_num_o,
  output logic [LINES-1:0] p_isr_set_o,
  output logic [LINES-1:0] p_pend_clr_o,
  output logic [LINES-1:0] s_isr_set_o,
  output logic [LINES-1:0] s_pend_clr_o,
  output logic             int_o,
  output logic [NCTL-1:0]  init_o,
  output logic [NCTL-1:0]  init4_o
);
  logic             s_hit, p_hit;
  logic [LW-1:0]    s_line, p_line;
  logic [LINES-1:0] p_req_eff;
  ack_kind_e        kind;
  logic [VW-1:0]    d_vec;
  logic [LW:0]      d_num;
  logic [LINES-1:0] d_pis, d_ppc, d_sis, d_spc;
  logic [NCTL-1:0]  start;
  logic             hold_q;

  // second controller arbitrated first: its result drives the cascade input
  cascade_line_arbiter #(.LINES(LINES)) sec_arb_i (
    .req_i(s_pend_i), .msk_i(s_mask_i), .isr_i(s_isr_i), .rot_i(s_rot_i),
    .hit_o(s_hit), .line_o(s_line)
  );

  always_comb begin
    p_req_eff = p_pend_i;
    p_req_eff[CASC_LINE] = p_pend_i[CASC_LINE] | s_hit;
  end

  cascade_line_arbiter #(.LINES(LINES)) pri_arb_i (
    .req_i(p_req_eff), .msk_i(p_mask_i), .isr_i(p_isr_i), .rot_i(p_rot_i),
    .hit_o(p_hit), .line_o(p_line)
  );

  cascade_ack_decode #(.LINES(LINES), .VW(VW), .CASC_LINE(CASC_LINE)) dec_i (
    .p_hit_i(p_hit), .p_line_i(p_line), .s_hit_i(s_hit), .s_line_i(s_line),
    .p_base_i(p_base_i), .s_base_i(s_base_i),
    .p_aeoi_i(p_aeoi_i), .s_aeoi_i(s_aeoi_i),
    .p_lvl_i(p_lvl_i), .s_lvl_i(s_lvl_i),
    .kind_o(kind), .vec_o(d_vec), .num_o(d_num),
    .p_isr_set_o(d_pis), .p_pend_clr_o(d_ppc),
    .s_isr_set_o(d_sis), .s_pend_clr_o(d_spc)
  );

  for (genvar c = 0; c < NCTL; c++) begin : g_init
    cascade_init_track #(.DW(DW)) trk_i (
      .clk(clk), .rst(rst),
      .wr_i(cmd_wr_i && (cmd_dst_i == 1'(c))),
      .data_i(cmd_data_i),
      .start_o(start[c]), .init_o(init_o[c]), .init4_o(init4_o[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o        <= '0;
      vec_vld_o    <= 1'b0;
      req_num_o    <= '0;
      p_isr_set_o  <= '0;
      p_pend_clr_o <= '0;
      s_isr_set_o  <= '0;
      s_pend_clr_o <= '0;
    end else begin
      vec_vld_o <= ack_i;
      if (ack_i) begin
        vec_o        <= d_vec;
        req_num_o    <= d_num;
        p_isr_set_o  <= d_pis;
        p_pend_clr_o <= d_ppc;
        s_isr_set_o  <= d_sis;
        s_pend_clr_o <= d_spc;
      end else begin
        p_isr_set_o  <= '0;
        p_pend_clr_o <= '0;
        s_isr_set_o  <= '0;
        s_pend_clr_o <= '0;
      end
    end
  end

  // interrupt line held low while the external state absorbs an update
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      int_o  <= 1'b0;
    end else begin
      hold_q <= ack_i || (|start);
      int_o  <= (ack_i || (|start) || hold_q) ? 1'b0 : p_hit;
    end
  end

  logic unused_kind;
  assign unused_kind = ^kind;
endmodule

// File: rtl/cascade_ack_chk.sv
module cascade_ack_chk #(
  parameter int LINES = 8,
  parameter int DW    = 8,
  parameter int NCTL  = 2,
  localparam int LW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             p_aeoi_i,
  input logic [LINES-1:0] p_lvl_i,
  input logic             cmd_wr_i,
  input logic [DW-1:0]    cmd_data_i,
  input logic             vec_vld_o,
  input logic [LW:0]      req_num_o,
  input logic [LINES-1:0] p_isr_set_o,
  input logic [LINES-1:0] p_pend_clr_o,
  input logic [LINES-1:0] s_isr_set_o,
  input logic [LINES-1:0] s_pend_clr_o,
  input logic             int_o,
  input logic [NCTL-1:0]  init_o
);
  // R10
  vld_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> vec_vld_o);
  // R10
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !vec_vld_o);
  // R8
  aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && p_aeoi_i) |=> (p_isr_set_o == '0));
  // R9
  level_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> ((p_pend_clr_o & $past(p_lvl_i)) == '0));
  // R11
  int_low_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !int_o);
  // R12
  int_low_after_init_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_i && cmd_data_i[4]) |=> !int_o);
  // R4
  pri_strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_isr_set_o | p_pend_clr_o));
  // R5
  sec_strobe_needs_casc_chk: assert property (@(posedge clk) disable iff (rst)
    ((s_isr_set_o | s_pend_clr_o) != '0) |-> (req_num_o[LW] && $onehot0(s_isr_set_o | s_pend_clr_o)));
  // R12
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (init_o != '0) |-> ($onehot0(init_o) && $past(cmd_wr_i)));
endmodule

bind cascade_ack_resolver cascade_ack_chk #(.LINES(LINES), .DW(DW), .NCTL(NCTL)) chk_i (
  .clk(clk), .rst(rst), .ack_i(ack_i), .p_aeoi_i(p_aeoi_i), .p_lvl_i(p_lvl_i),
  .cmd_wr_i(cmd_wr_i), .cmd_data_i(cmd_data_i), .vec_vld_o(vec_vld_o),
  .req_num_o(req_num_o), .p_isr_set_o(p_isr_set_o), .p_pend_clr_o(p_pend_clr_o),
  .s_isr_set_o(s_isr_set_o), .s_pend_clr_o(s_pend_clr_o), .int_o(int_o),
  .init_o(init_o)
);

// File: tb/cascade_ack_resolver_tb_top.sv
module cascade_ack_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ack_i = 1'b0;
  logic [7:0] p_pend_i = '0, p_mask_i = '0, p_isr_i = '0, p_lvl_i = '0;
  logic [7:0] s_pend_i = '0, s_mask_i = '0, s_isr_i = '0, s_lvl_i = '0;
  logic [4:0] p_base_i = 5'h01, s_base_i = 5'h0E;
  logic [2:0] p_rot_i = '0, s_rot_i = '0;
  logic       p_aeoi_i = 1'b0, s_aeoi_i = 1'b0;
  logic       cmd_wr_i = 1'b0, cmd_dst_i = 1'b0;
  logic [7:0] cmd_data_i = '0;
  logic [7:0] vec_o;
  logic       vec_vld_o;
  logic [3:0] req_num_o;
  logic [7:0] p_isr_set_o, p_pend_clr_o, s_isr_set_o, s_pend_clr_o;
  logic       int_o;
  logic [1:0] init_o, init4_o;

  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  cascade_ack_resolver dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    p_pend_i = '0; p_mask_i = '0; p_isr_i = '0; p_lvl_i = '0;
    s_pend_i = '0; s_mask_i = '0; s_isr_i = '0; s_lvl_i = '0;
    p_rot_i = '0; s_rot_i = '0; p_aeoi_i = 1'b0; s_aeoi_i = 1'b0;
  endtask

  // raise ack for one cycle; return sampled after the registering edge
  task automatic pulse_ack();
    ack_i = 1'b1;
    @(posedge clk); @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic check_ack(input string tag, input logic [7:0] v, input logic [3:0] n,
                           input logic [7:0] pis, input logic [7:0] ppc,
                           input logic [7:0] sis, input logic [7:0] spc);
    pulse_ack();
    chk({tag, " vec"}, vec_o, v);
    chk({tag, " num"}, req_num_o, n);
    chk({tag, " p_isr_set"}, p_isr_set_o, pis);
    chk({tag, " p_pend_clr"}, p_pend_clr_o, ppc);
    chk({tag, " s_isr_set"}, s_isr_set_o, sis);
    chk({tag, " s_pend_clr"}, s_pend_clr_o, spc);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 vld", vec_vld_o, 0);
    chk("R13 vec", vec_o, 0);
    chk("R13 int", int_o, 0);
    chk("R13 init4", init4_o, 0);
    chk("R13 strobes", {p_isr_set_o, p_pend_clr_o, s_isr_set_o, s_pend_clr_o}, 0);
  endtask

  task automatic t_primary();
    clear_all(); p_pend_i = 8'h12;
    check_ack("R4 line1", 8'h09, 4'd1, 8'h02, 8'h02, 8'h00, 8'h00);
  endtask

  task automatic t_rotation();
    clear_all(); p_pend_i = 8'h12; p_rot_i = 3'd3;
    check_ack("R1 rot3", 8'h0C, 4'd4, 8'h10, 8'h10, 8'h00, 8'h00);
    p_rot_i = 3'd5;
    check_ack("R1 rot5", 8'h09, 4'd1, 8'h02, 8'h02, 8'h00, 8'h00);
  endtask

  task automatic t_mask();
    clear_all(); p_pend_i = 8'h12; p_mask_i = 8'h02;
    check_ack("R3 masked", 8'h0C, 4'd4, 8'h10, 8'h10, 8'h00, 8'h00);
  endtask

  task automatic t_isr_block();
    clear_all(); p_pend_i = 8'h10; p_isr_i = 8'h08;
    check_ack("R2 higher isr", 8'h0F, 4'd7, 8'h00, 8'h00, 8'h00, 8'h00);
    p_isr_i = 8'h10;
    check_ack("R2 equal isr", 8'h0F, 4'd7, 8'h00, 8'h00, 8'h00, 8'h00);
    p_isr_i = 8'h20;
    check_ack("R2 lower isr", 8'h0C, 4'd4, 8'h10, 8'h10, 8'h00, 8'h00);
    p_isr_i = 8'h01; p_rot_i = 3'd3;
    check_ack("R2 rotated isr", 8'h0C, 4'd4, 8'h10, 8'h10, 8'h00, 8'h00);
  endtask

  task automatic t_cascade();
    clear_all(); s_pend_i = 8'h20;
    check_ack("R5 cascade", 8'h75, 4'd13, 8'h04, 8'h04, 8'h20, 8'h20);
    p_pend_i = 8'h02;
    check_ack("R5 primary higher", 8'h09, 4'd1, 8'h02, 8'h02, 8'h00, 8'h00);
    p_pend_i = 8'h08;
    check_ack("R5 cascade beats 3", 8'h75, 4'd13, 8'h04, 8'h04, 8'h20, 8'h20);
  endtask

  task automatic t_spurious();
    clear_all(); p_pend_i = 8'h04;
    check_ack("R6 sec empty", 8'h77, 4'd15, 8'h04, 8'h04, 8'h00, 8'h00);
    s_pend_i = 8'h01; s_mask_i = 8'h01;
    check_ack("R6 sec masked", 8'h77, 4'd15, 8'h04, 8'h04, 8'h00, 8'h00);
    clear_all();
    check_ack("R7 pri empty", 8'h0F, 4'd7, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_aeoi_level();
    clear_all(); p_pend_i = 8'h40; p_aeoi_i = 1'b1; p_lvl_i = 8'h40;
    check_ack("R8 R9 aeoi level", 8'h0E, 4'd6, 8'h00, 8'h00, 8'h00, 8'h00);
    p_aeoi_i = 1'b0;
    check_ack("R9 level", 8'h0E, 4'd6, 8'h40, 8'h00, 8'h00, 8'h00);
    p_aeoi_i = 1'b1; p_lvl_i = 8'h00;
    check_ack("R8 aeoi edge", 8'h0E, 4'd6, 8'h00, 8'h40, 8'h00, 8'h00);
    clear_all(); s_pend_i = 8'h08; s_aeoi_i = 1'b1; s_lvl_i = 8'h08;
    check_ack("R8 R9 sec", 8'h73, 4'd11, 8'h04, 8'h04, 8'h00, 8'h00);
  endtask

  task automatic t_valid();
    clear_all(); p_pend_i = 8'h01;
    chk("R10 idle", vec_vld_o, 0);
    pulse_ack();
    chk("R10 pulse", vec_vld_o, 1);
    @(posedge clk); @(negedge clk);
    chk("R10 drop", vec_vld_o, 0);
  endtask

  task automatic t_int();
    clear_all(); p_pend_i = 8'h12;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R11 settled", int_o, 1);
    pulse_ack();
    chk("R11 low1", int_o, 0);
    p_pend_i = 8'h10; p_isr_i = 8'h00;
    @(posedge clk); @(negedge clk);
    chk("R11 low2", int_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R11 back", int_o, 1);
    p_isr_i = 8'h02;
    @(posedge clk); @(negedge clk);
    chk("R11 blocked", int_o, 0);
  endtask

  task automatic t_init();
    clear_all(); p_pend_i = 8'h02;
    repeat (3) @(posedge clk); @(negedge clk);
    cmd_wr_i = 1'b1; cmd_dst_i = 1'b1; cmd_data_i = 8'h11;
    @(posedge clk); @(negedge clk);
    cmd_wr_i = 1'b0;
    chk("R12 strobe", init_o, 2'b10);
    chk("R12 ic4", init4_o, 2'b10);
    chk("R12 int low1", int_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R12 strobe end", init_o, 2'b00);
    chk("R12 int low2", int_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R12 int back", int_o, 1);
    cmd_wr_i = 1'b1; cmd_data_i = 8'h00;
    @(posedge clk); @(negedge clk);
    cmd_wr_i = 1'b0;
    chk("R12 non-init strobe", init_o, 2'b00);
    chk("R12 non-init ic4", init4_o, 2'b10);
    chk("R12 non-init int", int_o, 1);
    cmd_wr_i = 1'b1; cmd_dst_i = 1'b0; cmd_data_i = 8'h11;
    @(posedge clk); @(negedge clk);
    cmd_wr_i = 1'b0;
    chk("R12 primary strobe", init_o, 2'b01);
    chk("R12 primary ic4", init4_o, 2'b11);
    cmd_wr_i = 1'b1; cmd_dst_i = 1'b1; cmd_data_i = 8'h10;
    @(posedge clk); @(negedge clk);
    cmd_wr_i = 1'b0;
    chk("R12 ic4 clear", init4_o, 2'b01);
  endtask

  initial begin
    #(4 * 100000);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_primary();
    t_rotation();
    t_mask();
    t_isr_block();
    t_cascade();
    t_spurious();
    t_aeoi_level();
    t_valid();
    t_int();
    t_init();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule